// File: doc/BRIEF.md
# Quasi-Resonant Off-Time and Valley-Switching Controller

This block sequences the gate of a flyback power switch in quasi-resonant operation. It runs from a fast system clock and counts time through a one-cycle microsecond pulse, `us_tick`. A coded load level chooses how long the switch must stay off after each turn-off. Near full load the off-time is short, and it grows as the load falls, up to milliseconds at very light load. After turn-off the block masks the ringing for a short window and raises a one-clock strobe so the output over-voltage sense can be sampled. Once the minimum off-time has passed, it accepts a valley indication from the analog detector and turns the switch on after a short fixed delay. If no valley arrives, a time-out turns the switch on anyway.

Each conduction interval ends on a current-sense trip or at a hard on-time cap. The trip is masked for a few clocks after turn-on to reject the leading-edge spike. When enable rises, a starter timer launches the first pulse, and a soft-start level ramps from zero to full scale for the downstream peak-current comparator. Valley sensing and compensation of the current limit are analog functions and sit outside this block.

Top module: `qr_valley_ctrl`

## Requirements
- R1: While `rst_n` is low, and while `en` is low, `gate`, `ovp_strobe` and `ss_limit` read 0. `gate` and `ss_limit` are 0 one clock after `en` is sampled low.
- R2: After `en` rises, the first turn-on comes at the clock edge that samples the 32nd `us_tick` if `load_lvl` is 15 (open-loop zone). For any other code it comes at the 2500th tick.
- R3: The minimum off-time, in ticks, comes from `load_lvl` as sampled at turn-off. Codes 12 to 15 give 8. Codes 6 to 11 give 8 + floor((12 - code) * 29 / 6), so code 6 gives 37. Codes below 6 give 37 + floor((6 - code) * 2463 / 6), so code 0 gives 2500.
- R4: With no valley, the gate turns on at the edge that samples the tick completing (minimum off-time + 9) ticks after turn-off.
- R5: `valley` is ignored until the minimum off-time has elapsed, and that includes the 4-tick post-turn-off blanking.
- R6: An accepted `valley` turns the gate on `VDLY_CYC` clocks after the edge that samples it.
- R7: `ovp_strobe` is a one-clock pulse. It appears exactly once per off period, in the clock after the edge that samples the 4th tick after turn-off, and never while `gate` is high.
- R8: The gate falls at the edge that samples the 45th tick after turn-on.
- R9: `cs_trip` has no effect during the first `LEB_CYC` clocks of an on period. A trip held from turn-on gives a pulse of exactly `LEB_CYC` + 1 clocks.
- R10: `ss_limit` goes up by 1 for every 37 ticks after `en` rises (9500 / 255 ticks per step). It reaches 255 after 9435 ticks, then holds, and never falls while `en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Switching enable; low forces the gate off |
| us_tick | input | 1 | One-clock pulse per microsecond |
| load_lvl | input | 4 | Coded feedback zone, 15 = open loop, 0 = lightest load |
| valley | input | 1 | Valley seen on the auxiliary winding |
| cs_trip | input | 1 | Peak-current comparator tripped |
| gate | output | 1 | Power switch gate drive |
| ovp_strobe | output | 1 | Sample pulse for output over-voltage sensing |
| ss_limit | output | 8 | Soft-start current-limit level |

## Verification
The bench sweeps the load code over every interpolation segment and both ends. A one-off error in the off-time arithmetic, or in latching the code at turn-off, would move the fallback turn-on by a tick. Valley pulses are placed inside the blanking window and just before arming. A design that armed too early would turn on there instead of at the time-out. Current-sense trips are placed inside the leading-edge mask and held across it, so the test catches a mask that is one clock short or long and an on-time cap counted from the wrong edge. The starter and soft-start ramp are checked at the exact tick counts where they change, which would expose a ramp that starts one tick early or never saturates.

// File: rtl/qr_pkg.sv
package qr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_ON,
    S_OFF,
    S_VDLY
  } qr_state_e;

  // Minimum off-time in ticks for a load code: flat above the fast code,
  // one linear segment down to the green code, a second one down to code 0.
  function automatic int unsigned min_off_ticks(
    input int unsigned code,
    input int unsigned fast_code,
    input int unsigned green_code,
    input int unsigned t_fast,
    input int unsigned t_green,
    input int unsigned t_light
  );
    if (code >= fast_code)
      return t_fast;
    else if (code >= green_code)
      return t_fast + ((fast_code - code) * (t_green - t_fast)) / (fast_code - green_code);
    else
      return t_green + ((green_code - code) * (t_light - t_green)) / green_code;
  endfunction

  // Starter interval in ticks for a load code.
  function automatic int unsigned starter_ticks(
    input int unsigned code,
    input int unsigned olp_code,
    input int unsigned t_olp,
    input int unsigned t_slow
  );
    return (code >= olp_code) ? t_olp : t_slow;
  endfunction

endpackage

// File: rtl/qr_off_timer.sv
module qr_off_timer #(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned BLANK_US = 4,
  parameter int unsigned TMO_US   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] min_off,
  output logic             armed,
  output logic             tmo_fire,
  output logic             ovp_strobe
);

  localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_US - 1);
  localparam logic [CNT_W-1:0] TMO_ADD    = CNT_W'(TMO_US - 1);

  logic [CNT_W-1:0] off_cnt;
  logic [CNT_W-1:0] tmo_at;

  assign tmo_at   = min_off + TMO_ADD;
  assign armed    = (off_cnt >= min_off);
  assign tmo_fire = run && us_tick && (off_cnt == tmo_at);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt    <= '0;
      ovp_strobe <= 1'b0;
    end else begin
      ovp_strobe <= run && us_tick && (off_cnt == BLANK_LAST);
      if (restart)
        off_cnt <= '0;
      else if (run && us_tick && (off_cnt != '1))
        off_cnt <= off_cnt + 1'b1;
    end
  end

  // R7
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_strobe |=> !ovp_strobe);

  // R4
  tmo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> !run);

endmodule

// File: rtl/qr_on_timer.sv
module qr_on_timer #(
  parameter int unsigned MAXON_US = 45,
  parameter int unsigned LEB_CYC  = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic run,
  input  logic cs_trip,
  output logic leb_done,
  output logic max_fire,
  output logic off_req
);

  localparam int unsigned ON_W  = $clog2(MAXON_US + 1);
  localparam int unsigned LEB_W = $clog2(LEB_CYC + 1);
  localparam logic [ON_W-1:0]  ON_LAST = ON_W'(MAXON_US - 1);
  localparam logic [LEB_W-1:0] LEB_END = LEB_W'(LEB_CYC);

  logic [ON_W-1:0]  on_cnt;
  logic [LEB_W-1:0] leb_cnt;
  logic             trip_fire;

  assign leb_done  = (leb_cnt == LEB_END);
  assign max_fire  = run && us_tick && (on_cnt == ON_LAST);
  assign trip_fire = run && leb_done && cs_trip;
  assign off_req   = max_fire || trip_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt  <= '0;
      leb_cnt <= '0;
    end else if (!run) begin
      on_cnt  <= '0;
      leb_cnt <= '0;
    end else begin
      if (us_tick)
        on_cnt <= on_cnt + 1'b1;
      if (!leb_done)
        leb_cnt <= leb_cnt + 1'b1;
    end
  end

  // R8
  max_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_fire |=> !run);

endmodule

// File: rtl/qr_softstart.sv
module qr_softstart #(
  parameter int unsigned SS_W     = 8,
  parameter int unsigned SS_TICKS = 9500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            us_tick,
  output logic [SS_W-1:0] ss_limit
);

  localparam int unsigned SS_MAX  = (1 << SS_W) - 1;
  localparam int unsigned SS_STEP = (SS_TICKS / SS_MAX < 1) ? 1 : SS_TICKS / SS_MAX;
  localparam int unsigned STEP_W  = $clog2(SS_STEP + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SS_STEP - 1);
  localparam logic [SS_W-1:0]   LVL_TOP   = SS_W'(SS_MAX);

  logic [STEP_W-1:0] step_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= '0;
      ss_limit <= '0;
    end else if (!en) begin
      step_cnt <= '0;
      ss_limit <= '0;
    end else if (us_tick) begin
      if (step_cnt == STEP_LAST) begin
        step_cnt <= '0;
        if (ss_limit != LVL_TOP)
          ss_limit <= ss_limit + 1'b1;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  // R10
  ss_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> (ss_limit >= $past(ss_limit)));

  // R10
  ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !us_tick) |=> $stable(ss_limit) || !en);

endmodule

// File: rtl/qr_valley_ctrl.sv
module qr_valley_ctrl #(
  parameter int unsigned LVL_W      = 4,
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned FAST_CODE  = 12,
  parameter int unsigned GREEN_CODE = 6,
  parameter int unsigned OLP_CODE   = 15,
  parameter int unsigned TOFF_FAST  = 8,
  parameter int unsigned TOFF_GREEN = 37,
  parameter int unsigned TOFF_LIGHT = 2500,
  parameter int unsigned BLANK_US   = 4,
  parameter int unsigned TMO_US     = 9,
  parameter int unsigned MAXON_US   = 45,
  parameter int unsigned ST_SLOW    = 2500,
  parameter int unsigned ST_OLP     = 32,
  parameter int unsigned VDLY_CYC   = 25,
  parameter int unsigned LEB_CYC    = 38,
  parameter int unsigned SS_TICKS   = 9500,
  parameter int unsigned SS_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             us_tick,
  input  logic [LVL_W-1:0] load_lvl,
  input  logic             valley,
  input  logic             cs_trip,
  output logic             gate,
  output logic             ovp_strobe,
  output logic [SS_W-1:0]  ss_limit
);

  import qr_pkg::*;

  localparam int unsigned DLY_W = $clog2(VDLY_CYC + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(VDLY_CYC - 1);

  qr_state_e        state, nxt;
  logic [CNT_W-1:0] min_off_q;
  logic [CNT_W-1:0] st_cnt;
  logic [CNT_W-1:0] st_lim;
  logic [DLY_W-1:0] dly_cnt;

  // named internal events
  logic st_fire, vdly_done, tmo_fire, armed, valley_take;
  logic off_req, leb_done, max_fire, turn_off;
  logic on_run, off_run;

  assign on_run  = (state == S_ON);
  assign off_run = (state == S_OFF);
  assign gate    = on_run;

  assign st_lim      = CNT_W'(starter_ticks(32'(load_lvl), OLP_CODE, ST_OLP, ST_SLOW));
  assign st_fire     = (state == S_START) && us_tick && (st_cnt == st_lim - CNT_W'(1));
  assign vdly_done   = (state == S_VDLY) && (dly_cnt == DLY_LAST);
  assign valley_take = off_run && armed && valley && !tmo_fire;
  assign turn_off    = on_run && off_req && en;

  qr_off_timer #(
    .CNT_W    (CNT_W),
    .BLANK_US (BLANK_US),
    .TMO_US   (TMO_US)
  ) u_off (
    .clk        (clk),
    .rst_n      (rst_n),
    .us_tick    (us_tick),
    .restart    (turn_off),
    .run        (off_run),
    .min_off    (min_off_q),
    .armed      (armed),
    .tmo_fire   (tmo_fire),
    .ovp_strobe (ovp_strobe)
  );

  qr_on_timer #(
    .MAXON_US (MAXON_US),
    .LEB_CYC  (LEB_CYC)
  ) u_on (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .run      (on_run),
    .cs_trip  (cs_trip),
    .leb_done (leb_done),
    .max_fire (max_fire),
    .off_req  (off_req)
  );

  qr_softstart #(
    .SS_W     (SS_W),
    .SS_TICKS (SS_TICKS)
  ) u_ss (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .us_tick  (us_tick),
    .ss_limit (ss_limit)
  );

  always_comb begin
    nxt = state;
    if (!en) begin
      nxt = S_IDLE;
    end else begin
      case (state)
        S_IDLE:  nxt = S_START;
        S_START: if (st_fire) nxt = S_ON;
        S_ON:    if (off_req) nxt = S_OFF;
        S_OFF: begin
          if (tmo_fire)         nxt = S_ON;
          else if (valley_take) nxt = S_VDLY;
        end
        S_VDLY:  if (vdly_done) nxt = S_ON;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      min_off_q <= CNT_W'(TOFF_FAST);
      st_cnt    <= '0;
      dly_cnt   <= '0;
    end else begin
      state <= nxt;
      if (turn_off)
        min_off_q <= CNT_W'(min_off_ticks(32'(load_lvl), FAST_CODE, GREEN_CODE,
                                          TOFF_FAST, TOFF_GREEN, TOFF_LIGHT));
      if (state != S_START)
        st_cnt <= '0;
      else if (us_tick)
        st_cnt <= st_cnt + 1'b1;
      if (state != S_VDLY)
        dly_cnt <= '0;
      else
        dly_cnt <= dly_cnt + 1'b1;
    end
  end

  // R1
  en_low_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate);

  // R2 R4 R6
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(st_fire || vdly_done || tmo_fire));

  // R5
  early_valley_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_run && valley && !armed && !tmo_fire && en) |=> (state == S_OFF));

  // R7
  strobe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_strobe |-> !gate);

  // R9
  leb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_run && !leb_done && !max_fire && en) |=> gate);

endmodule

// File: tb/test_qr_valley_ctrl.sv
`timescale 1ns/1ps
module test_qr_valley_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       us_tick;
  logic [3:0] load_lvl;
  logic       valley;
  logic       cs_trip;
  logic       gate;
  logic       ovp_strobe;
  logic [7:0] ss_limit;

  int n_chk = 0;
  int n_bad = 0;
  int ph = 0;

  localparam int VDLY = 3;
  localparam int LEB  = 5;
  localparam int NVEC = 10;
  // load code, expected minimum off-time in ticks (R3)
  localparam int VEC_CODE [NVEC] = '{15, 13, 12, 10, 9, 7, 6, 5, 3, 0};
  localparam int VEC_TOFF [NVEC] = '{ 8,  8,  8, 17, 22, 32, 37, 447, 1268, 2500};

  always #4 clk = ~clk;

  qr_valley_ctrl #(
    .VDLY_CYC (VDLY),
    .LEB_CYC  (LEB)
  ) i_qr_valley_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .us_tick    (us_tick),
    .load_lvl   (load_lvl),
    .valley     (valley),
    .cs_trip    (cs_trip),
    .gate       (gate),
    .ovp_strobe (ovp_strobe),
    .ss_limit   (ss_limit)
  );

  // one tick every four clocks
  initial begin
    us_tick = 1'b0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      us_tick = (ph == 0);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic off_period(input int v1, input int v2,
                            output int ticks, output int nstb, output int stb_at);
    ticks = 0; nstb = 0; stb_at = -1;
    while (gate == 1'b0) begin
      if (ovp_strobe) begin nstb++; stb_at = ticks; end
      valley = us_tick && (ticks == v1 || ticks == v2);
      if (us_tick) ticks++;
      step();
    end
    valley = 1'b0;
  endtask

  task automatic on_period(input int trip_len, input logic trip_after,
                           output int ticks, output int cycles, output int stb_on);
    ticks = 0; cycles = 0; stb_on = 0;
    while (gate == 1'b1) begin
      cs_trip = (cycles < trip_len) ? 1'b1 : trip_after;
      if (ovp_strobe) stb_on++;
      if (us_tick) ticks++;
      cycles++;
      step();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t, c, s, nstb, sat, first_rise;
    rst_n = 1'b0; en = 1'b0; load_lvl = 4'd12; valley = 1'b0; cs_trip = 1'b1;
    repeat (5) step();
    // R1 reset state
    chk("R1", "gate in reset", gate, 0);
    chk("R1", "strobe in reset", ovp_strobe, 0);
    chk("R1", "ss_limit in reset", ss_limit, 0);
    rst_n = 1'b1;
    repeat (10) step();
    chk("R1", "gate with en low", gate, 0);

    // R2 starter, normal zone
    while (us_tick) step();
    en = 1'b1;
    step();
    t = 0;
    while (gate == 1'b0) begin
      if (us_tick) t++;
      step();
    end
    chk("R2", "starter ticks code 12", t, 2500);

    // R9 trip held from turn-on
    on_period(1000, 1'b1, t, c, s);
    chk("R9", "pulse clocks with held trip", c, LEB + 1);
    chk("R7", "strobe while gate high", s, 0);

    // R3 R4 R7 vector table
    for (int i = 0; i < NVEC; i++) begin
      while (gate == 1'b0) step();
      load_lvl = 4'(VEC_CODE[i]);
      while (gate == 1'b1) step();
      off_period(-1, -1, t, nstb, sat);
      chk("R3_R4", $sformatf("off ticks code %0d", VEC_CODE[i]), t, VEC_TOFF[i] + 9);
      chk("R7", $sformatf("strobe count code %0d", VEC_CODE[i]), nstb, 1);
      chk("R7", $sformatf("strobe position code %0d", VEC_CODE[i]), sat, 4);
    end

    // R5 early valleys ignored (blanking and pre-arm)
    while (gate == 1'b0) step();
    load_lvl = 4'd12;
    while (gate == 1'b1) step();
    off_period(-1, -1, t, nstb, sat);
    while (gate == 1'b1) step();
    off_period(2, 6, t, nstb, sat);
    chk("R5", "off ticks with early valleys", t, 17);

    // R6 armed valley
    while (gate == 1'b1) step();
    t = 0;
    while (t < 10) begin
      if (us_tick) t++;
      step();
    end
    valley = 1'b1;
    step();
    valley = 1'b0;
    c = 1;
    while (gate == 1'b0) begin
      step();
      c++;
    end
    chk("R6", "valley to gate clocks", c, VDLY + 1);

    // R8 R9 early trip inside blanking, then max on-time
    on_period(2, 1'b0, t, c, s);
    chk("R8", "on ticks at cap", t, 45);
    chk("R9", "early trip ignored", (c > LEB + 1) ? 1 : 0, 1);
    cs_trip = 1'b1;

    // R1 en drop
    en = 1'b0;
    step();
    chk("R1", "gate after en low", gate, 0);
    chk("R1", "ss_limit after en low", ss_limit, 0);

    // R2 open-loop starter and R10 soft-start ramp
    load_lvl = 4'd15;
    while (us_tick) step();
    en = 1'b1;
    step();
    t = 0;
    first_rise = -1;
    while (t <= 9500) begin
      if (gate && first_rise < 0) first_rise = t;
      if (us_tick) begin
        case (t)
          0:    chk("R10", "ss at start", ss_limit, 0);
          36:   chk("R10", "ss before first step", ss_limit, 0);
          37:   chk("R10", "ss first step", ss_limit, 1);
          74:   chk("R10", "ss second step", ss_limit, 2);
          9434: chk("R10", "ss before top", ss_limit, 254);
          9435: chk("R10", "ss at top", ss_limit, 255);
          9500: chk("R10", "ss saturated", ss_limit, 255);
          default: ;
        endcase
        t++;
      end
      step();
    end
    chk("R2", "starter ticks open loop", first_rise, 32);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule